// File: doc/BRIEF.md
# Multi-Channel Burst DMA Engine

This block moves data between an external burst memory and per-core local RAM buffers. Each core owns one channel. A core programs its channel with a single command that carries an operation, an external word address, a local word address and a byte count. While a channel is busy, its status shows the current external and local addresses.

The engine cuts every transfer into fixed-length bursts. It services the busy channels in rotation, one burst per turn, so every requester sees data moving soon after it issues a command. Refresh requests for the external memory come from an internal interval timer. They go out only between bursts, never inside one. Data crosses the local side at one 32-bit word per clock. Read data is written into local RAM as each beat arrives. Write data is fetched from local RAM one cycle ahead of each beat it feeds.

Top module: `dma_burst_engine`

## Requirements
- R1: After reset, every channel is not busy with its error flag clear, and no memory request, local write or local read is asserted.
- R2: A read command (op code 1) copies external words starting at the channel's external address into that channel's local buffer starting at its local address. The local write is asserted in the same cycle as each memory read beat, one word per clock.
- R3: A write command (op code 2) copies local words into the external memory. Exactly one write beat is driven per fetched local word, and only inside a granted write burst.
- R4: The byte count is rounded up to whole bursts of BURST_LEN 32-bit words (default 8 words, 32 bytes). Exactly that many words move and the word after the last one is untouched. A count of zero moves nothing and leaves the channel not busy.
- R5: Busy rises on the cycle after an accepted transfer command and falls after the last burst. While busy, the status addresses either hold or advance by exactly BURST_LEN. At completion they equal the start address plus the number of moved words, with the local address wrapping modulo the local depth.
- R6: When several channels are busy, successive bursts go to the next busy channel after the one served last, in ascending cyclic order. The first pick after reset is channel 0.
- R7: A refresh request (memory op code 3) is issued once every REFRESH_INTERVAL cycles when the engine is idle. It is never issued between a data burst's grant and its last beat.
- R8: Any command to a busy channel is ignored and sets that channel's error flag. The flag stays set until an init command is accepted on an idle channel.
- R9: An init command (op code 0, and the reserved op code 3) on an idle channel loads both status addresses, ignores the byte count, clears the error flag and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NUM_CH | Per-channel command strobe |
| cmd_op | input | NUM_CH x 2 | Per-channel operation: 0 init, 1 read, 2 write, 3 init |
| cmd_ext | input | NUM_CH x EXT_W | External start word address |
| cmd_loc | input | NUM_CH x LOC_W | Local start word address |
| cmd_bytes | input | NUM_CH x CNT_W | Byte count |
| ch_busy | output | NUM_CH | Channel has bursts outstanding |
| ch_err | output | NUM_CH | Sticky command-while-busy flag |
| ch_ext_addr | output | NUM_CH x EXT_W | Current external word address |
| ch_loc_addr | output | NUM_CH x LOC_W | Current local word address |
| mem_req | output | 1 | Burst or refresh request |
| mem_op | output | 2 | 1 read burst, 2 write burst, 3 refresh |
| mem_addr | output | EXT_W | Burst start word address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | DATA_W | Write beat data |
| loc_sel | output | IDX_W | Channel whose local RAM is accessed |
| loc_we | output | 1 | Local RAM write |
| loc_re | output | 1 | Local RAM read (data due next cycle) |
| loc_addr | output | LOC_W | Local RAM word address |
| loc_wdata | output | DATA_W | Local RAM write data |
| loc_rdata | input | DATA_W | Local RAM read data, one cycle after loc_re |

## Verification
The interleaving order is the hardest case to produce from the ports, because it only shows when several channels are busy at the same moment. The bench strobes all four command inputs in one cycle, each asking for three bursts. It then logs the channel of every granted burst and compares the log with the expected cyclic order. A second pattern with only two busy channels, following a known last-served channel, checks that idle channels are skipped. A command aimed at a channel in mid-transfer confirms that the running transfer's addresses and data are unaffected.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        CMD_INIT  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        MOP_NONE    = 2'd0,
        MOP_READ    = 2'd1,
        MOP_WRITE   = 2'd2,
        MOP_REFRESH = 2'd3
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_PICK,
        ST_REQ,
        ST_RDATA,
        ST_WDATA,
        ST_REFRESH
    } eng_state_e;

    typedef struct packed {
        logic busy;
        logic wr;
        logic err;
    } ch_flags_t;

    function automatic int unsigned index_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
    import dma_pkg::*;
#(
    parameter int EXT_W     = 16,
    parameter int LOC_W     = 8,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [EXT_W-1:0] cmd_ext,
    input  logic [LOC_W-1:0] cmd_loc,
    input  logic [CNT_W-1:0] cmd_bytes,
    input  logic             burst_done,
    output ch_flags_t        flags,
    output logic [EXT_W-1:0] ext_addr,
    output logic [LOC_W-1:0] loc_addr
);
    localparam int BURST_BYTES = BURST_LEN * 4;
    localparam int BYTE_SH     = $clog2(BURST_BYTES);

    logic [CNT_W:0]   padded;
    logic [CNT_W-1:0] n_bursts;
    logic [CNT_W-1:0] left_q;
    cmd_op_e          op;

    assign op       = cmd_op_e'(cmd_op);
    assign padded   = {1'b0, cmd_bytes} + (CNT_W+1)'(BURST_BYTES - 1);
    assign n_bursts = CNT_W'(padded >> BYTE_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            ext_addr <= '0;
            loc_addr <= '0;
            left_q   <= '0;
        end else begin
            if (cmd_valid && flags.busy) begin
                flags.err <= 1'b1;
            end
            if (cmd_valid && !flags.busy) begin
                ext_addr <= cmd_ext;
                loc_addr <= cmd_loc;
                if (op == CMD_READ || op == CMD_WRITE) begin
                    left_q     <= n_bursts;
                    flags.busy <= (n_bursts != '0);
                    flags.wr   <= (op == CMD_WRITE);
                end else begin
                    left_q     <= '0;
                    flags.busy <= 1'b0;
                    flags.wr   <= 1'b0;
                    flags.err  <= 1'b0;
                end
            end else if (burst_done) begin
                ext_addr   <= ext_addr + EXT_W'(BURST_LEN);
                loc_addr   <= loc_addr + LOC_W'(BURST_LEN);
                left_q     <= left_q - 1'b1;
                flags.busy <= (left_q != CNT_W'(1));
            end
        end
    end

endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W = index_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic              advance,
    output logic              any,
    output logic [IDX_W-1:0]  pick
);
    logic [IDX_W-1:0] last_q;

    always_comb begin
        any  = 1'b0;
        pick = last_q;
        for (int k = NUM_CH; k >= 1; k--) begin
            if (req[(int'(last_q) + k) % NUM_CH]) begin
                any  = 1'b1;
                pick = IDX_W'((int'(last_q) + k) % NUM_CH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(NUM_CH - 1);
        end else if (advance && any) begin
            last_q <= pick;
        end
    end

endmodule

// File: rtl/dma_refresh_tick.sv
module dma_refresh_tick #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic served,
    output logic due
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) begin
                due <= 1'b1;
            end else if (served) begin
                due <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
    import dma_pkg::*;
#(
    parameter int NUM_CH           = 4,
    parameter int EXT_W            = 16,
    parameter int LOC_W            = 8,
    parameter int CNT_W            = 16,
    parameter int DATA_W           = 32,
    parameter int BURST_LEN        = 8,
    parameter int REFRESH_INTERVAL = 390,
    localparam int IDX_W           = index_width(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CH-1:0]            cmd_valid,
    input  logic [NUM_CH-1:0][1:0]       cmd_op,
    input  logic [NUM_CH-1:0][EXT_W-1:0] cmd_ext,
    input  logic [NUM_CH-1:0][LOC_W-1:0] cmd_loc,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmd_bytes,
    output logic [NUM_CH-1:0]            ch_busy,
    output logic [NUM_CH-1:0]            ch_err,
    output logic [NUM_CH-1:0][EXT_W-1:0] ch_ext_addr,
    output logic [NUM_CH-1:0][LOC_W-1:0] ch_loc_addr,
    output logic                         mem_req,
    output logic [1:0]                   mem_op,
    output logic [EXT_W-1:0]             mem_addr,
    input  logic                         mem_gnt,
    input  logic                         mem_rvalid,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         mem_wvalid,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic [IDX_W-1:0]             loc_sel,
    output logic                         loc_we,
    output logic                         loc_re,
    output logic [LOC_W-1:0]             loc_addr,
    output logic [DATA_W-1:0]            loc_wdata,
    input  logic [DATA_W-1:0]            loc_rdata
);
    localparam int BEAT_W = $clog2(BURST_LEN) + 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
    localparam logic [BEAT_W-1:0] ALL_BEATS = BEAT_W'(BURST_LEN);

    eng_state_e       state_q, state_d;
    logic [IDX_W-1:0] cur_q;
    logic [BEAT_W-1:0] beat_q, wbeat_q;
    logic             wv_q;
    logic             burst_done;
    logic             ref_due, ref_served;
    logic             arb_any, arb_adv;
    logic [IDX_W-1:0] arb_pick;

    ch_flags_t        flags [NUM_CH];
    logic [EXT_W-1:0] ext_a [NUM_CH];
    logic [LOC_W-1:0] loc_a [NUM_CH];

    // One context per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic done_here;
        assign done_here = burst_done && (cur_q == IDX_W'(g));

        dma_chan_ctx #(
            .EXT_W(EXT_W), .LOC_W(LOC_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)
        ) u_ctx (
            .clk(clk), .rst(rst),
            .cmd_valid(cmd_valid[g]), .cmd_op(cmd_op[g]),
            .cmd_ext(cmd_ext[g]), .cmd_loc(cmd_loc[g]), .cmd_bytes(cmd_bytes[g]),
            .burst_done(done_here),
            .flags(flags[g]), .ext_addr(ext_a[g]), .loc_addr(loc_a[g])
        );

        assign ch_busy[g]     = flags[g].busy;
        assign ch_err[g]      = flags[g].err;
        assign ch_ext_addr[g] = ext_a[g];
        assign ch_loc_addr[g] = loc_a[g];
    end

    assign arb_adv = (state_q == ST_PICK) && !ref_due;

    dma_rr_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst(rst), .req(ch_busy), .advance(arb_adv),
        .any(arb_any), .pick(arb_pick)
    );

    dma_refresh_tick #(.INTERVAL(REFRESH_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .served(ref_served), .due(ref_due)
    );

    assign loc_sel   = cur_q;
    assign loc_wdata = mem_rdata;
    assign mem_wdata = loc_rdata;
    assign mem_wvalid = wv_q;

    always_comb begin
        state_d    = state_q;
        mem_req    = 1'b0;
        mem_op     = MOP_NONE;
        mem_addr   = '0;
        loc_we     = 1'b0;
        loc_re     = 1'b0;
        loc_addr   = loc_a[cur_q] + LOC_W'(beat_q);
        burst_done = 1'b0;
        ref_served = 1'b0;
        unique case (state_q)
            ST_PICK: begin
                if (ref_due)      state_d = ST_REFRESH;
                else if (arb_any) state_d = ST_REQ;
            end
            ST_REQ: begin
                mem_req  = 1'b1;
                mem_op   = flags[cur_q].wr ? MOP_WRITE : MOP_READ;
                mem_addr = ext_a[cur_q];
                if (mem_gnt) state_d = flags[cur_q].wr ? ST_WDATA : ST_RDATA;
            end
            ST_RDATA: begin
                loc_we = mem_rvalid;
                if (mem_rvalid && beat_q == LAST_BEAT) begin
                    burst_done = 1'b1;
                    state_d    = ST_PICK;
                end
            end
            ST_WDATA: begin
                loc_re = (beat_q != ALL_BEATS);
                if (wv_q && wbeat_q == LAST_BEAT) begin
                    burst_done = 1'b1;
                    state_d    = ST_PICK;
                end
            end
            ST_REFRESH: begin
                mem_req = 1'b1;
                mem_op  = MOP_REFRESH;
                if (mem_gnt) begin
                    ref_served = 1'b1;
                    state_d    = ST_PICK;
                end
            end
            default: state_d = ST_PICK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PICK;
            cur_q   <= '0;
            beat_q  <= '0;
            wbeat_q <= '0;
            wv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            wv_q    <= loc_re;
            if (arb_adv && arb_any) cur_q <= arb_pick;
            if (state_q == ST_REQ && mem_gnt) begin
                beat_q  <= '0;
                wbeat_q <= '0;
            end
            if (state_q == ST_RDATA && mem_rvalid) beat_q <= beat_q + 1'b1;
            if (loc_re) beat_q <= beat_q + 1'b1;
            if (wv_q) wbeat_q <= wbeat_q + 1'b1;
        end
    end

endmodule

// File: rtl/dma_burst_engine_chk.sv
module dma_burst_engine_chk #(
    parameter int NUM_CH    = 4,
    parameter int EXT_W     = 16,
    parameter int BURST_LEN = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            cmd_valid,
    input logic [NUM_CH-1:0][1:0]       cmd_op,
    input logic [NUM_CH-1:0]            ch_busy,
    input logic [NUM_CH-1:0]            ch_err,
    input logic [NUM_CH-1:0][EXT_W-1:0] ch_ext_addr,
    input logic                         mem_req,
    input logic [1:0]                   mem_op,
    input logic                         mem_gnt,
    input logic                         mem_rvalid,
    input logic                         mem_wvalid,
    input logic                         loc_we,
    input logic                         loc_re
);
    localparam int LW = $clog2(BURST_LEN) + 1;

    logic [LW-1:0] rleft_q, wleft_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rleft_q <= '0;
            wleft_q <= '0;
        end else begin
            if (mem_req && mem_gnt && mem_op == 2'd1) rleft_q <= LW'(BURST_LEN);
            else if (mem_rvalid && rleft_q != '0)     rleft_q <= rleft_q - 1'b1;
            if (mem_req && mem_gnt && mem_op == 2'd2) wleft_q <= LW'(BURST_LEN);
            else if (mem_wvalid && wleft_q != '0)     wleft_q <= wleft_q - 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ch_busy == '0 && ch_err == '0 && !mem_req && !loc_we && !loc_re));

    assert_local_write_on_beat_R2: assert property (@(posedge clk) disable iff (rst)
        loc_we |-> (mem_rvalid && rleft_q != '0));

    assert_local_port_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(loc_we && loc_re));

    assert_wbeat_in_burst_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid |-> (wleft_q != '0));

    assert_refresh_between_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op == 2'd3) |-> (rleft_q == '0 && wleft_q == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_idle_stays_R4: assert property (@(posedge clk) disable iff (rst)
            (!ch_busy[i] && !cmd_valid[i]) |=> !ch_busy[i]);

        assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
            ch_busy[i] |=> (ch_ext_addr[i] == $past(ch_ext_addr[i]) ||
                            ch_ext_addr[i] == $past(ch_ext_addr[i]) + EXT_W'(BURST_LEN)));

        assert_busy_cmd_err_R8: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid[i] && ch_busy[i]) |=> ch_err[i]);

        assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (ch_err[i] && !(cmd_valid[i] && !ch_busy[i] &&
                            (cmd_op[i] == 2'd0 || cmd_op[i] == 2'd3))) |=> ch_err[i]);
    end

endmodule

bind dma_burst_engine dma_burst_engine_chk #(
    .NUM_CH(NUM_CH), .EXT_W(EXT_W), .BURST_LEN(BURST_LEN)
) u_chk (.*);

// File: tb/dma_burst_engine_test.sv
module dma_burst_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int EW    = 16;
    localparam int LW    = 8;
    localparam int CW    = 16;
    localparam int DW    = 32;
    localparam int BL    = 8;
    localparam int REF_INT = 40;
    localparam int LDEPTH  = 1 << LW;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]         cmd_valid = '0;
    logic [NCH-1:0][1:0]    cmd_op = '0;
    logic [NCH-1:0][EW-1:0] cmd_ext = '0;
    logic [NCH-1:0][LW-1:0] cmd_loc = '0;
    logic [NCH-1:0][CW-1:0] cmd_bytes = '0;
    logic [NCH-1:0]         ch_busy, ch_err;
    logic [NCH-1:0][EW-1:0] ch_ext_addr;
    logic [NCH-1:0][LW-1:0] ch_loc_addr;
    logic mem_req, mem_gnt, mem_rvalid, mem_wvalid, loc_we, loc_re;
    logic [1:0] mem_op;
    logic [EW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, mem_wdata, loc_wdata;
    logic [DW-1:0] loc_rdata = '0;
    logic [1:0] loc_sel;
    logic [LW-1:0] loc_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_burst_engine #(
        .NUM_CH(NCH), .EXT_W(EW), .LOC_W(LW), .CNT_W(CW), .DATA_W(DW),
        .BURST_LEN(BL), .REFRESH_INTERVAL(REF_INT)
    ) uut (.*);

    // behavioral burst memory and local RAMs
    logic [31:0] ext_mem [4096];
    logic [31:0] loc_ram [NCH*LDEPTH];
    int rd_left = 0, wr_left = 0;
    logic [EW-1:0] rd_ptr = '0, wr_ptr = '0;
    int ref_cnt = 0, order_n = 0;
    bit midburst = 0;
    logic [1:0] order_log [64];

    function automatic logic [31:0] ext_pat(int a);
        return 32'hE17A_0000 | (a & 32'hFFFF);
    endfunction
    function automatic logic [31:0] loc_pat(int ch, int a);
        return 32'hC0DE_0000 + ch * 256 + a;
    endfunction

    assign mem_gnt    = mem_req;
    assign mem_rvalid = (rd_left != 0);
    assign mem_rdata  = ext_pat(int'(rd_ptr));

    always @(posedge clk) begin
        if (loc_we) loc_ram[int'(loc_sel) * LDEPTH + int'(loc_addr)] = loc_wdata;
        if (loc_re) loc_rdata <= loc_ram[int'(loc_sel) * LDEPTH + int'(loc_addr)];
        if (mem_req && mem_op == 2'd3) begin
            ref_cnt = ref_cnt + 1;
            if (rd_left != 0 || wr_left != 0) midburst = 1;
        end
        if (mem_req && (mem_op == 2'd1 || mem_op == 2'd2) && order_n < 64) begin
            order_log[order_n] = loc_sel;
            order_n = order_n + 1;
        end
        if (mem_req && mem_op == 2'd1) begin
            rd_left <= BL; rd_ptr <= mem_addr;
        end else if (rd_left != 0) begin
            rd_left <= rd_left - 1; rd_ptr <= rd_ptr + 1'b1;
        end
        if (mem_req && mem_op == 2'd2) begin
            wr_left <= BL; wr_ptr <= mem_addr;
        end else if (mem_wvalid) begin
            ext_mem[int'(wr_ptr) & 12'hFFF] = mem_wdata;
            wr_ptr <= wr_ptr + 1'b1;
            wr_left <= wr_left - 1;
        end
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input int ch, input int op, input int ext, input int loc, input int bytes);
        @(negedge clk);
        cmd_valid[ch] = 1'b1;
        cmd_op[ch]    = 2'(op);
        cmd_ext[ch]   = EW'(ext);
        cmd_loc[ch]   = LW'(loc);
        cmd_bytes[ch] = CW'(bytes);
        @(negedge clk);
        cmd_valid = '0;
    endtask

    task automatic wait_all_idle();
        for (int n = 0; n < 3000 && ch_busy != '0; n++) @(negedge clk);
    endtask

    task automatic check_read(input int ch, input int ext, input int loc, input int words, input string tag);
        int bad = 0;
        logic [31:0] a = '0, e = '0;
        for (int i = 0; i < words; i++) begin
            logic [31:0] got;
            got = loc_ram[ch * LDEPTH + ((loc + i) % LDEPTH)];
            if (got !== ext_pat(ext + i) && bad == 0) begin a = got; e = ext_pat(ext + i); end
            if (got !== ext_pat(ext + i)) bad++;
        end
        chk(bad == 0, tag, a, e);
    endtask

    // ch, op, ext, loc, bytes
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{0, 1, 'h100, 'h00, 32},
        '{1, 1, 'h200, 'h10, 33},
        '{2, 2, 'h300, 'h20, 64},
        '{3, 2, 'h400, 'h40, 1},
        '{0, 1, 'h500, 'h80, 0},
        '{3, 1, 'h600, 'hF0, 96}
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) ext_mem[i] = SENT;
        for (int c = 0; c < NCH; c++)
            for (int a = 0; a < LDEPTH; a++) loc_ram[c * LDEPTH + a] = loc_pat(c, a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ch_busy == '0 && ch_err == '0, "R1 reset flags", {ch_busy, ch_err}, 0);
        chk(!mem_req && !loc_we && !loc_re, "R1 reset outputs", {mem_req, loc_we, loc_re}, 0);

        // table of single-channel transfers: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            int ch, op, ext, loc, bytes, words, n0;
            ch = VEC[v][0]; op = VEC[v][1]; ext = VEC[v][2]; loc = VEC[v][3]; bytes = VEC[v][4];
            words = ((bytes + BL * 4 - 1) / (BL * 4)) * BL;
            if (op == 1)
                for (int i = 0; i <= words; i++) loc_ram[ch * LDEPTH + ((loc + i) % LDEPTH)] = SENT;
            n0 = order_n;
            issue(ch, op, ext, loc, bytes);
            chk(ch_busy[ch] == (words != 0), "R5 busy after accept", 32'(ch_busy[ch]), 32'(words != 0));
            wait_all_idle();
            repeat (2) @(negedge clk);
            if (words == 0) begin
                chk(order_n == n0, "R4 zero count moves nothing", order_n, n0);
                chk(loc_ram[ch * LDEPTH + loc] == SENT, "R4 zero count buffer untouched",
                    loc_ram[ch * LDEPTH + loc], SENT);
            end else if (op == 1) begin
                check_read(ch, ext, loc, words, "R2 read data");
                chk(loc_ram[ch * LDEPTH + ((loc + words) % LDEPTH)] == SENT, "R4 read word past end",
                    loc_ram[ch * LDEPTH + ((loc + words) % LDEPTH)], SENT);
            end else begin
                int bad = 0;
                for (int i = 0; i < words; i++)
                    if (ext_mem[ext + i] !== loc_pat(ch, (loc + i) % LDEPTH)) bad++;
                chk(bad == 0, "R3 write data", bad, 0);
                chk(ext_mem[ext + words] == SENT, "R4 write word past end", ext_mem[ext + words], SENT);
            end
            chk(ch_ext_addr[ch] == EW'(ext + words), "R5 final ext addr", ch_ext_addr[ch], EW'(ext + words));
            chk(ch_loc_addr[ch] == LW'((loc + words) % LDEPTH), "R5 final loc addr",
                ch_loc_addr[ch], LW'((loc + words) % LDEPTH));
        end

        // R6 all four channels at once, 3 bursts each
        begin
            int r0, bad;
            for (int c = 0; c < NCH; c++)
                for (int i = 0; i <= 24; i++) loc_ram[c * LDEPTH + i] = SENT;
            order_n = 0;
            r0 = ref_cnt;
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                cmd_valid[c] = 1'b1; cmd_op[c] = 2'd1;
                cmd_ext[c] = EW'('h800 + c * 'h40); cmd_loc[c] = '0; cmd_bytes[c] = CW'(96);
            end
            @(negedge clk);
            cmd_valid = '0;
            wait_all_idle();
            repeat (2) @(negedge clk);
            bad = 0;
            for (int i = 0; i < 12; i++) if (order_log[i] != 2'(i % 4)) bad++;
            chk(order_n == 12 && bad == 0, "R6 four-way rotation", bad, 0);
            for (int c = 0; c < NCH; c++) check_read(c, 'h800 + c * 'h40, 0, 24, "R2 interleaved read data");
            chk(ref_cnt - r0 >= 1, "R7 refresh during busy run", ref_cnt - r0, 1);
        end

        // R6 two channels busy, idle ones skipped
        begin
            int bad;
            order_n = 0;
            @(negedge clk);
            cmd_valid[1] = 1'b1; cmd_op[1] = 2'd2; cmd_ext[1] = EW'('hA00); cmd_loc[1] = '0; cmd_bytes[1] = CW'(64);
            cmd_valid[3] = 1'b1; cmd_op[3] = 2'd2; cmd_ext[3] = EW'('hB00); cmd_loc[3] = '0; cmd_bytes[3] = CW'(64);
            @(negedge clk);
            cmd_valid = '0;
            wait_all_idle();
            repeat (2) @(negedge clk);
            chk(order_n == 4 && order_log[0] == 2'd1 && order_log[1] == 2'd3 &&
                order_log[2] == 2'd1 && order_log[3] == 2'd3, "R6 two-way rotation",
                {order_log[0], order_log[1], order_log[2], order_log[3]}, 8'b01110111);
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                if (ext_mem['hA00 + i] !== loc_ram[1 * LDEPTH + i]) bad++;
                if (ext_mem['hB00 + i] !== loc_ram[3 * LDEPTH + i]) bad++;
            end
            chk(bad == 0, "R3 interleaved write data", bad, 0);
        end

        // R8 command to a busy channel
        begin
            for (int i = 0; i <= 24; i++) loc_ram[2 * LDEPTH + 'h60 + i] = SENT;
            issue(2, 1, 'hC00, 'h60, 96);
            issue(2, 2, 'hD00, 'h90, 32);
            chk(ch_err[2] == 1'b1, "R8 error set on busy command", 32'(ch_err[2]), 1);
            wait_all_idle();
            repeat (2) @(negedge clk);
            chk(ch_ext_addr[2] == EW'('hC00 + 24), "R8 ignored command left addresses",
                ch_ext_addr[2], EW'('hC00 + 24));
            check_read(2, 'hC00, 'h60, 24, "R8 running transfer intact");
            chk(ext_mem['hD00] == SENT, "R8 ignored write not performed", ext_mem['hD00], SENT);
            chk(ch_err[2] == 1'b1, "R8 error sticky", 32'(ch_err[2]), 1);
            issue(2, 0, 'h123, 'h45, 64);
            chk(ch_err[2] == 1'b0 && ch_busy[2] == 1'b0, "R9 init clears error",
                {ch_err[2], ch_busy[2]}, 0);
            chk(ch_ext_addr[2] == EW'('h123) && ch_loc_addr[2] == LW'('h45), "R9 init loads addresses",
                {ch_ext_addr[2], ch_loc_addr[2]}, {16'h123, 8'h45});
            issue(1, 3, 'h77, 'h33, 64);
            repeat (3) @(negedge clk);
            chk(ch_busy[1] == 1'b0 && ch_ext_addr[1] == EW'('h77) && ch_loc_addr[1] == LW'('h33),
                "R9 reserved op acts as init", {ch_busy[1], ch_ext_addr[1], ch_loc_addr[1]},
                {1'b0, 16'h77, 8'h33});
        end

        // R7 idle refresh rate
        begin
            int r0;
            wait_all_idle();
            r0 = ref_cnt;
            repeat (10 * REF_INT) @(negedge clk);
            chk(ref_cnt - r0 == 10, "R7 idle refresh count", ref_cnt - r0, 10);
            chk(midburst == 0, "R7 no refresh inside burst", 32'(midburst), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule